// File: doc/BRIEF.md
# Integer Execution Unit with Registered Result

This block is the arithmetic and logic stage of a simple three-format RISC pipeline. Each cycle it accepts two 32-bit operands, a 5-bit shift distance, and the raw 6-bit opcode and 6-bit function fields of the instruction. It decodes those fields directly into one operation. The result, an equality flag for conditional branches, and a flag for unsupported codes are captured in an output register, so they appear one clock after the request.

Operand A comes from the first source register. Operand B comes from the second source register, or from the immediate for immediate-format instructions. The immediate arrives already sign-extended. The unit zero-extends it itself for OR-immediate, and moves it to the upper half for load-upper-immediate. Register writes, branch target arithmetic and everything else around the stage live outside the block.

Top module: `int_exec_unit`

## Requirements
- R1: Opcode 0 with function 32 (add), and opcode 8 (add-immediate), produce A+B modulo 2^32 with no overflow indication.
- R2: Opcode 0 with function 34 (subtract) produces A-B modulo 2^32.
- R3: Opcode 0 with functions 36, 37 and 39 produce A AND B, A OR B and NOT(A OR B). With B equal to zero, the last one gives the bitwise inverse of A.
- R4: Opcode 0 with function 42, and opcode 10 (set-less-than-immediate), write exactly 1 when A is less than B as two's-complement numbers and exactly 0 otherwise. Bits 31:1 are always zero.
- R5: Opcode 0 with function 43 compares A and B as unsigned numbers and writes 1 or 0. For A=0xFFFFFFFF and B=1 it writes 0, while function 42 writes 1.
- R6: Opcode 0 with function 0 shifts B left, and with function 2 shifts B right, by the shift-amount input. Vacated bits fill with zeros. All other operations ignore the shift amount.
- R7: Opcode 13 (OR-immediate) ORs A with B[15:0] zero-extended. B[31:16] has no effect on the result.
- R8: Opcode 15 (load-upper-immediate) produces B[15:0] in bits 31:16 and zeros in bits 15:0. A has no effect.
- R9: The zero flag is 1 exactly when A minus B is zero, for every code, comparing A and B as presented at the ports.
- R10: Opcode 0 with function 8 (register jump) is legal and returns A unchanged as the result.
- R11: Any opcode or function code not listed above gives a zero result with the illegal flag set. Every listed code gives an illegal flag of 0.
- R12: When the valid input is high, result, zero and illegal update at the next rising edge, and the valid output goes high. When the valid input is low, the valid output goes low and the other three outputs hold.
- R13: While the active-low reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| opcode | input | 6 | Instruction opcode field |
| funct | input | 6 | Function field, used when opcode is 0 |
| shamt | input | 5 | Shift distance |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand or sign-extended immediate |
| out_valid | output | 1 | Result valid, one cycle after request |
| result | output | 32 | Registered result |
| zero | output | 1 | Registered A-equals-B flag |
| illegal | output | 1 | Registered unsupported-code flag |

## Verification
The bench sweeps all 64 opcodes and all 64 function codes against a set of corner operands and pseudo-random operands.

- **Unlisted codes.** A decoder that treated any such code as legal would return a nonzero result or leave the illegal flag low.
- **Signed versus unsigned less-than.** The sign-boundary operands (0xFFFFFFFF against 1, and 0x80000000 against 0x7FFFFFFF) separate the two comparisons. Swapping them, or returning a full subtraction instead of a single bit, shows up at once.
- **Shift distances.** Every distance from 0 to 31 is checked in both directions. Shifting arithmetically, or shifting by the wrong barrel stage, leaves wrong bits at the edges.
- **Immediate forms.** These run with a B whose upper half is nonzero. Sign-extending the OR immediate, or keeping low bits for load-upper, is caught.
- **Hold behaviour.** A final idle cycle changes the inputs and checks that a hold regression does not alter the outputs.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

   typedef enum logic [3:0] {
      XOP_ADD   = 4'd0,
      XOP_SUB   = 4'd1,
      XOP_AND   = 4'd2,
      XOP_OR    = 4'd3,
      XOP_NOR   = 4'd4,
      XOP_SLT   = 4'd5,
      XOP_SLTU  = 4'd6,
      XOP_SHL   = 4'd7,
      XOP_SHR   = 4'd8,
      XOP_PASSA = 4'd9,
      XOP_UPPER = 4'd10,
      XOP_NONE  = 4'd15
   } xop_e;

   typedef enum logic [1:0] {
      BSEL_RAW  = 2'd0,
      BSEL_ZEXT = 2'd1
   } bsel_e;

   typedef struct packed {
      xop_e  op;
      bsel_e bsel;
      logic  bad;
   } xdec_t;

   // Opcode field values
   localparam logic [5:0] OPC_REG   = 6'd0;
   localparam logic [5:0] OPC_ADDI  = 6'd8;
   localparam logic [5:0] OPC_SLTI  = 6'd10;
   localparam logic [5:0] OPC_ORI   = 6'd13;
   localparam logic [5:0] OPC_UPPER = 6'd15;

   // Function field values (opcode 0)
   localparam logic [5:0] FN_SHL  = 6'd0;
   localparam logic [5:0] FN_SHR  = 6'd2;
   localparam logic [5:0] FN_JREG = 6'd8;
   localparam logic [5:0] FN_ADD  = 6'd32;
   localparam logic [5:0] FN_SUB  = 6'd34;
   localparam logic [5:0] FN_AND  = 6'd36;
   localparam logic [5:0] FN_OR   = 6'd37;
   localparam logic [5:0] FN_NOR  = 6'd39;
   localparam logic [5:0] FN_SLT  = 6'd42;
   localparam logic [5:0] FN_SLTU = 6'd43;

endpackage

// File: rtl/int_exec_decode.sv
module int_exec_decode
   import int_exec_pkg::*;
#(
   parameter int OPC_W = 6,
   parameter int FN_W  = 6
) (
   input  logic [OPC_W-1:0] opcode,
   input  logic [FN_W-1:0]  funct,
   output xdec_t            dec
);

   generate
      if (OPC_W != 6 || FN_W != 6) begin : g_bad_fields
         $error("int_exec_decode: opcode and function fields must be 6 bits");
      end
   endgenerate

   always_comb begin
      dec.op   = XOP_NONE;
      dec.bsel = BSEL_RAW;
      dec.bad  = 1'b0;
      unique case (opcode)
         OPC_REG: begin
            unique case (funct)
               FN_SHL:  dec.op = XOP_SHL;
               FN_SHR:  dec.op = XOP_SHR;
               FN_JREG: dec.op = XOP_PASSA;
               FN_ADD:  dec.op = XOP_ADD;
               FN_SUB:  dec.op = XOP_SUB;
               FN_AND:  dec.op = XOP_AND;
               FN_OR:   dec.op = XOP_OR;
               FN_NOR:  dec.op = XOP_NOR;
               FN_SLT:  dec.op = XOP_SLT;
               FN_SLTU: dec.op = XOP_SLTU;
               default: dec.bad = 1'b1;
            endcase
         end
         OPC_ADDI:  dec.op = XOP_ADD;
         OPC_SLTI:  dec.op = XOP_SLT;
         OPC_ORI: begin
            dec.op   = XOP_OR;
            dec.bsel = BSEL_ZEXT;
         end
         OPC_UPPER: dec.op = XOP_UPPER;
         default:   dec.bad = 1'b1;
      endcase
   end

endmodule

// File: rtl/int_exec_arith.sv
module int_exec_arith #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] sum,
   output logic [DATA_W-1:0] diff,
   output logic              lt_signed,
   output logic              lt_unsigned,
   output logic              equal
);

   logic [DATA_W:0] wide_diff;

   assign sum       = a + b;
   assign wide_diff = {1'b0, a} - {1'b0, b};
   assign diff      = wide_diff[DATA_W-1:0];
   // A borrow out of the top bit means a < b as unsigned numbers.
   assign lt_unsigned = wide_diff[DATA_W];
   // Signs differ: a negative a is the smaller one. Otherwise the difference cannot overflow.
   assign lt_signed = (a[DATA_W-1] != b[DATA_W-1]) ? a[DATA_W-1] : diff[DATA_W-1];
   assign equal     = (diff == '0);

endmodule

// File: rtl/int_exec_shift.sv
module int_exec_shift #(
   parameter int    DATA_W = 32,
   parameter string STYLE  = "STAGED",
   localparam int   AMT_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [AMT_W-1:0]  amt,
   output logic [DATA_W-1:0] shl,
   output logic [DATA_W-1:0] shr
);

   generate
      if (STYLE == "STAGED") begin : g_staged
         logic [DATA_W-1:0] lst [0:AMT_W];
         logic [DATA_W-1:0] rst_ [0:AMT_W];
         assign lst[0]  = din;
         assign rst_[0] = din;
         for (genvar k = 0; k < AMT_W; k++) begin : g_stage
            localparam int S = 2 ** k;
            assign lst[k+1]  = amt[k] ? {lst[k][DATA_W-1-S:0], {S{1'b0}}} : lst[k];
            assign rst_[k+1] = amt[k] ? {{S{1'b0}}, rst_[k][DATA_W-1:S]} : rst_[k];
         end
         assign shl = lst[AMT_W];
         assign shr = rst_[AMT_W];
      end else if (STYLE == "OPERATOR") begin : g_operator
         assign shl = din << amt;
         assign shr = din >> amt;
      end else begin : g_bad_style
         $error("int_exec_shift: STYLE must be STAGED or OPERATOR");
         assign shl = '0;
         assign shr = '0;
      end
   endgenerate

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
   import int_exec_pkg::*;
#(
   parameter int    DATA_W      = 32,
   parameter int    OPC_W       = 6,
   parameter int    FN_W        = 6,
   parameter string SHIFT_STYLE = "STAGED",
   localparam int   AMT_W       = $clog2(DATA_W),
   localparam int   IMM_W       = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [FN_W-1:0]   funct,
   input  logic [AMT_W-1:0]  shamt,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              zero,
   output logic              illegal
);

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("int_exec_unit: DATA_W must be a power of two, at least 8");
      end
   endgenerate

   xdec_t             dec;
   logic [DATA_W-1:0] b_eff;
   logic [DATA_W-1:0] sum, diff, shl, shr;
   logic              lt_s, lt_u, eq;
   logic [DATA_W-1:0] res_d;

   int_exec_decode #(.OPC_W(OPC_W), .FN_W(FN_W)) u_dec (
      .opcode (opcode),
      .funct  (funct),
      .dec    (dec)
   );

   assign b_eff = (dec.bsel == BSEL_ZEXT) ? {{(DATA_W-IMM_W){1'b0}}, op_b[IMM_W-1:0]} : op_b;

   int_exec_arith #(.DATA_W(DATA_W)) u_arith (
      .a           (op_a),
      .b           (op_b),
      .sum         (sum),
      .diff        (diff),
      .lt_signed   (lt_s),
      .lt_unsigned (lt_u),
      .equal       (eq)
   );

   int_exec_shift #(.DATA_W(DATA_W), .STYLE(SHIFT_STYLE)) u_shift (
      .din (op_b),
      .amt (shamt),
      .shl (shl),
      .shr (shr)
   );

   always_comb begin
      res_d = '0;
      if (!dec.bad) begin
         unique case (dec.op)
            XOP_ADD:   res_d = sum;
            XOP_SUB:   res_d = diff;
            XOP_AND:   res_d = op_a & b_eff;
            XOP_OR:    res_d = op_a | b_eff;
            XOP_NOR:   res_d = ~(op_a | b_eff);
            XOP_SLT:   res_d = {{(DATA_W-1){1'b0}}, lt_s};
            XOP_SLTU:  res_d = {{(DATA_W-1){1'b0}}, lt_u};
            XOP_SHL:   res_d = shl;
            XOP_SHR:   res_d = shr;
            XOP_PASSA: res_d = op_a;
            XOP_UPPER: res_d = {op_b[IMM_W-1:0], {IMM_W{1'b0}}};
            default:   res_d = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         zero      <= 1'b0;
         illegal   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result  <= res_d;
            zero    <= eq;
            illegal <= dec.bad;
         end
      end
   end

   // R12: a request produces a valid output on the next edge.
   assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R12: with no request, the outputs hold.
   assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result) && $stable(zero) && $stable(illegal)));
   // R11: a flagged code never carries a nonzero result.
   assert_illegal_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && illegal) |-> (result == '0));
   // R9: the zero flag reflects operand equality of the request.
   assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (zero == ($past(op_a) == $past(op_b))));
   // R4: the less-than results occupy only bit 0.
   assert_slt_single_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dec.bad && (dec.op == XOP_SLT || dec.op == XOP_SLTU))
      |=> (result[DATA_W-1:1] == '0));
   // R8: load-upper clears the low half.
   assert_upper_low_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dec.bad && dec.op == XOP_UPPER) |=> (result[IMM_W-1:0] == '0));

endmodule

// File: tb/int_exec_unit_tb.sv
`timescale 1ns/1ps
module int_exec_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [5:0]  opcode = '0;
   logic [5:0]  funct = '0;
   logic [4:0]  shamt = '0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic        out_valid;
   logic [31:0] result;
   logic        zero;
   logic        illegal;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [31:0] lfsr = 32'h1234_5678;

   always #2 clk = ~clk;

   int_exec_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .funct(funct), .shamt(shamt), .op_a(op_a), .op_b(op_b),
      .out_valid(out_valid), .result(result), .zero(zero), .illegal(illegal)
   );

   function automatic logic [31:0] next_rand(logic [31:0] s);
      logic [31:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   // Reference model built from the requirement text.
   task automatic model(input logic [5:0] opc, input logic [5:0] fn, input logic [4:0] sh,
                        input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] r, output logic bad, output string tag);
      r = 32'h0; bad = 1'b0; tag = "R11";
      if (opc == 6'd0) begin
         case (fn)
            6'd0:  begin r = b << sh;                         tag = "R6";  end
            6'd2:  begin r = b >> sh;                         tag = "R6";  end
            6'd8:  begin r = a;                               tag = "R10"; end
            6'd32: begin r = a + b;                           tag = "R1";  end
            6'd34: begin r = a - b;                           tag = "R2";  end
            6'd36: begin r = a & b;                           tag = "R3";  end
            6'd37: begin r = a | b;                           tag = "R3";  end
            6'd39: begin r = ~(a | b);                        tag = "R3";  end
            6'd42: begin r = ($signed(a) < $signed(b)) ? 1 : 0; tag = "R4"; end
            6'd43: begin r = (a < b) ? 1 : 0;                 tag = "R5";  end
            default: bad = 1'b1;
         endcase
      end else begin
         case (opc)
            6'd8:  begin r = a + b;                           tag = "R1";  end
            6'd10: begin r = ($signed(a) < $signed(b)) ? 1 : 0; tag = "R4"; end
            6'd13: begin r = a | {16'h0, b[15:0]};            tag = "R7";  end
            6'd15: begin r = {b[15:0], 16'h0};                tag = "R8";  end
            default: bad = 1'b1;
         endcase
      end
   endtask

   task automatic run(input logic [5:0] opc, input logic [5:0] fn, input logic [4:0] sh,
                      input logic [31:0] a, input logic [31:0] b);
      logic [31:0] er;
      logic eb;
      string tag;
      @(negedge clk);
      opcode = opc; funct = fn; shamt = sh; op_a = a; op_b = b; in_valid = 1'b1;
      model(opc, fn, sh, a, b, er, eb, tag);
      @(negedge clk);
      n_run++;
      if (!out_valid || result !== er || illegal !== eb) begin
         n_fail++;
         $display("FAIL %s opc=%0d fn=%0d sh=%0d a=%h b=%h: got v=%b r=%h ill=%b, expected v=1 r=%h ill=%b",
                  tag, opc, fn, sh, a, b, out_valid, result, illegal, er, eb);
      end
      n_run++;
      if (zero !== (a == b)) begin // R9
         n_fail++;
         $display("FAIL R9 a=%h b=%h: got zero=%b, expected %b", a, b, zero, (a == b));
      end
   endtask

   initial begin
      logic [31:0] corners [8];
      logic [31:0] hr;
      logic hz, hi;
      corners = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                  32'h7FFF_FFFF, 32'h0000_3C00, 32'h0000_0DC0, 32'hABCD_8765};
      repeat (3) @(negedge clk);
      // R13: outputs cleared during reset
      n_run++;
      if (out_valid !== 1'b0 || result !== 32'h0 || zero !== 1'b0 || illegal !== 1'b0) begin
         n_fail++;
         $display("FAIL R13 got v=%b r=%h z=%b ill=%b, expected all zero",
                  out_valid, result, zero, illegal);
      end
      rst_n = 1'b1;

      // Directed corners: R5 sign boundary, R3 NOT via NOR with zero, R1 wrap
      run(6'd0, 6'd42, 5'd7, 32'hFFFF_FFFF, 32'h1);
      run(6'd0, 6'd43, 5'd7, 32'hFFFF_FFFF, 32'h1);
      run(6'd0, 6'd39, 5'd0, 32'h0000_3C00, 32'h0);
      run(6'd0, 6'd32, 5'd0, 32'hFFFF_FFFF, 32'h2);
      run(6'd15, 6'd0, 5'd3, 32'hDEAD_BEEF, 32'hFFFF_8005);
      run(6'd13, 6'd0, 5'd3, 32'h1000_0001, 32'hFFFF_8002);

      // Sweep every function code, then every opcode, over operand pairs
      for (int fn = 0; fn < 64; fn++) begin
         for (int k = 0; k < 8; k++) begin
            lfsr = next_rand(lfsr);
            run(6'd0, 6'(fn), lfsr[4:0], corners[k], (k % 2 == 0) ? corners[7-k] : lfsr);
         end
      end
      for (int opc = 1; opc < 64; opc++) begin
         for (int k = 0; k < 8; k++) begin
            lfsr = next_rand(lfsr);
            run(6'(opc), lfsr[10:5], lfsr[4:0], (k % 2 == 0) ? lfsr : corners[k], corners[7-k] ^ {lfsr[31:16], 16'h0});
         end
      end
      // R6: every shift distance in both directions
      for (int s = 0; s < 32; s++) begin
         lfsr = next_rand(lfsr);
         run(6'd0, 6'd0, 5'(s), lfsr, 32'h8000_0001);
         run(6'd0, 6'd2, 5'(s), lfsr, 32'h8000_0001);
         run(6'd0, 6'd0, 5'(s), 32'h0, lfsr);
         run(6'd0, 6'd2, 5'(s), 32'h0, lfsr);
      end

      // R12: idle cycle with new inputs keeps outputs and drops valid
      run(6'd0, 6'd32, 5'd0, 32'h0000_0005, 32'h0000_0005);
      hr = result; hz = zero; hi = illegal;
      @(negedge clk);
      in_valid = 1'b0; opcode = 6'd63; op_a = 32'h1; op_b = 32'h2;
      @(negedge clk);
      n_run++;
      if (out_valid !== 1'b0 || result !== hr || zero !== hz || illegal !== hi) begin
         n_fail++;
         $display("FAIL R12 idle: got v=%b r=%h z=%b ill=%b, expected v=0 r=%h z=%b ill=%b",
                  out_valid, result, zero, illegal, hr, hz, hi);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule